// File: doc/BRIEF.md
# Dual-Ratio Synchronized Clock Divider

The block takes one input clock and produces two divided clocks, each with its complement. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter, one fifth or one sixth of the input rate. Both dividers advance on the same rising edges, start from the same launch edge and stop on the same edges, so any edge the two outputs have in common falls on the same input edge.

A single freeze input pauses both dividers. It is captured on the falling edge of the input clock. A pause therefore begins or ends only while the input clock is low, and no shortened pulse can appear on either output.

Ratio selects are sampled on every rising edge, reset included. A divider applies a new ratio only when it starts a new period, so it never emits a partial period. An active-low reset clears both outputs at once. The first advancing edge after reset drives both outputs high together, and that edge is the common alignment point for any number of blocks that share the reset.

Top module: `twindiv_top`

## Requirements
- R1: With `sel_a` = 0, output A divides by 2: high for 1 input cycle, then low for 1. With `sel_a` = 1, it divides by 4: high for 2 cycles, then low for 2.
- R2: Output B's ratio comes from `sel_b`. Code 2'b00 divides by 4 (2 high, 2 low). Code 2'b01 divides by 6 (3 high, 3 low). Codes 2'b10 and 2'b11 both divide by 5 (2 high, 3 low).
- R3: While `rst_n` is low, `qa` and `qb` are low and `qa_n` and `qb_n` are high. This takes effect immediately, without waiting for a clock edge.
- R4: The first advancing rising edge after reset is released drives `qa` and `qb` high on that same edge.
- R5: The value of `freeze` at a falling clock edge decides the next rising edge. If it is 1, that edge leaves both outputs unchanged; if it is 0, both dividers advance.
- R6: A `freeze` pulse that begins and ends inside the clock-high phase, without spanning a falling edge, has no effect on the outputs.
- R7: Both dividers advance on exactly the same rising edges, so the position of each output within its period follows from one common count of advancing edges since launch.
- R8: A select value sampled on a rising edge takes effect only when the divider next starts a period (at launch or after its last cycle). The period in progress completes at the old ratio.
- R9: `qa_n` and `qb_n` are always the exact inverses of `qa` and `qb`, including during reset and freeze.
- R10: With `freeze`, `sel_a` and `sel_b` all low, the block divides by 2 on A and by 4 on B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, shared by both dividers |
| freeze | input | 1 | 1 pauses both dividers; captured on the falling clock edge |
| sel_a | input | 1 | Output A ratio: 0 selects /2, 1 selects /4 |
| sel_b | input | 2 | Output B ratio code: 00 selects /4, 01 selects /6, 1x selects /5 |
| qa | output | 1 | Divided clock A |
| qa_n | output | 1 | Inverse of qa |
| qb | output | 1 | Divided clock B |
| qb_n | output | 1 | Inverse of qb |

## Verification
Each output change is due on the rising edge that advances it, and the bench samples every output 2 ns after each rising edge. A `freeze` level counts only for the rising edge that follows the falling edge that captured it. A select level present at rising edge k governs the first period start at edge k+1 or later. The bench reproduces these offsets with a model that counts advancing edges from the launch edge. Reset is checked a fraction of a nanosecond after `rst_n` falls, before any clock edge. The freeze glitch cases place their pulses relative to the falling edge: one pulse lies wholly inside the high phase, and one spans exactly one falling edge.

// File: rtl/twindiv_pkg.sv
`timescale 1ns/1ps
// twindiv_pkg: shared types and helpers for the dual-ratio divider.
// Assumes ratios are small positive integers (>= 2).
package twindiv_pkg;

    // Output B ratio code as seen on sel_b.
    typedef enum logic [1:0] {
        B_CODE_QUAD    = 2'b00,
        B_CODE_HEX     = 2'b01,
        B_CODE_PENTA_A = 2'b10,
        B_CODE_PENTA_B = 2'b11
    } b_code_e;

    // Registered select pins.
    typedef struct packed {
        logic       a;
        logic [1:0] b;
    } sel_t;

    function automatic int max3(input int x, input int y, input int z);
        int m;
        m = (x > y) ? x : y;
        return (m > z) ? m : z;
    endfunction

    function automatic int min3(input int x, input int y, input int z);
        int m;
        m = (x < y) ? x : y;
        return (m < z) ? m : z;
    endfunction

endpackage

// File: rtl/twindiv_hold_sync.sv
`timescale 1ns/1ps
// twindiv_hold_sync: captures the freeze request on the falling clock
// edge so the dividers can only start or stop while the clock is low.
// Assumes freeze is stable around the falling edge of clk.
module twindiv_hold_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    output logic hold_q
);

    // Falling-edge capture of the pause request; reset means running.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= freeze;
        end
    end

endmodule

// File: rtl/twindiv_sel_reg.sv
`timescale 1ns/1ps
// twindiv_sel_reg: samples the ratio select pins on every rising edge
// (reset included, so the launch period already sees them) and decodes
// them into ratio values for the two dividers.
// Assumes the select pins are held for at least one rising edge.
module twindiv_sel_reg #(
    parameter int RW   = 3,
    parameter int A_LO = 2,
    parameter int A_HI = 4,
    parameter int B_00 = 4,
    parameter int B_01 = 6,
    parameter int B_1X = 5
) (
    input  logic          clk,
    input  logic          sel_a,
    input  logic [1:0]    sel_b,
    output logic [RW-1:0] ratio_a,
    output logic [RW-1:0] ratio_b
);
    import twindiv_pkg::*;

    sel_t sel_q;

    // Select sampling register; deliberately free of reset so it tracks the pins during reset.
    always_ff @(posedge clk) begin
        sel_q <= '{a: sel_a, b: sel_b};
    end

    // Output A ratio decode.
    always_comb begin
        ratio_a = sel_q.a ? RW'(A_HI) : RW'(A_LO);
    end

    // Output B ratio decode: both codes with the upper bit set select /5.
    always_comb begin
        case (b_code_e'(sel_q.b))
            B_CODE_QUAD:    ratio_b = RW'(B_00);
            B_CODE_HEX:     ratio_b = RW'(B_01);
            B_CODE_PENTA_A: ratio_b = RW'(B_1X);
            default:        ratio_b = RW'(B_1X);
        endcase
    end

endmodule

// File: rtl/twindiv_divider.sv
`timescale 1ns/1ps
// twindiv_divider: one programmable divider. A period of R input cycles
// starts high and stays high for floor(R/2) cycles. A new ratio is
// loaded only at a period start (launch or terminal count).
// Assumes ratio_in >= 2 and that adv/restart are common to all dividers.
module twindiv_divider #(
    parameter int RW    = 3,
    parameter int MIN_R = 2,
    parameter int MAX_R = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          restart,
    input  logic [RW-1:0] ratio_in,
    output logic          q
);

    logic [RW-1:0] cnt_q;
    logic [RW-1:0] ratio_q;
    logic [RW-1:0] cnt_nx;
    logic          period_start;
    logic          q_r;

    // Next position within the period and period-start detection.
    always_comb begin
        cnt_nx       = cnt_q + RW'(1);
        period_start = restart || (cnt_q == ratio_q - RW'(1));
    end

    // Period counter, active ratio and output level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= RW'(MIN_R);
            q_r     <= 1'b0;
        end else if (adv) begin
            if (period_start) begin
                cnt_q   <= '0;
                ratio_q <= ratio_in;
                q_r     <= 1'b1;
            end else begin
                cnt_q   <= cnt_nx;
                q_r     <= (cnt_nx < (ratio_q >> 1));
            end
        end
    end

    assign q = q_r;

    // R5: a paused edge leaves the output and its position untouched.
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(q_r) && $stable(cnt_q)))
        else $error("p_hold_stable_r5");

    // R8: the active ratio changes only at a period start.
    p_ratio_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !period_start) |=> $stable(ratio_q))
        else $error("p_ratio_at_start_r8");

    // R1: every period starts with the output high.
    p_period_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && period_start) |=> q_r)
        else $error("p_period_high_r1");

    // R2: once launched, the active ratio lies within this divider's range.
    p_ratio_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (ratio_q >= RW'(MIN_R) && ratio_q <= RW'(MAX_R)))
        else $error("p_ratio_legal_r2");

endmodule

// File: rtl/twindiv_top.sv
`timescale 1ns/1ps
// twindiv_top: two lockstep clock dividers (A: /2 or /4, B: /4, /5, /6)
// sharing one pause control, one launch flag and one reset.
// Assumes rst_n is asserted once after power-up before outputs are used.
module twindiv_top #(
    parameter int A_LO = 2,
    parameter int A_HI = 4,
    parameter int B_00 = 4,
    parameter int B_01 = 6,
    parameter int B_1X = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze,
    input  logic       sel_a,
    input  logic [1:0] sel_b,
    output logic       qa,
    output logic       qa_n,
    output logic       qb,
    output logic       qb_n
);
    import twindiv_pkg::*;

    localparam int RMAX  = max3(max3(A_LO, A_HI, 0), max3(B_00, B_01, B_1X), 0);
    localparam int RW    = $clog2(RMAX + 1);
    localparam int NDIV  = 2;
    localparam int A_MIN = (A_LO < A_HI) ? A_LO : A_HI;
    localparam int A_MAX = (A_LO > A_HI) ? A_LO : A_HI;
    localparam int B_MIN = min3(B_00, B_01, B_1X);
    localparam int B_MAX = max3(B_00, B_01, B_1X);

    logic            hold_q;
    logic            adv;
    logic            launched_q;
    logic [RW-1:0]   ratio_a;
    logic [RW-1:0]   ratio_b;
    logic [RW-1:0]   ratio_v [NDIV];
    logic [NDIV-1:0] div_q;

    twindiv_hold_sync u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (freeze),
        .hold_q (hold_q)
    );

    twindiv_sel_reg #(
        .RW   (RW),
        .A_LO (A_LO),
        .A_HI (A_HI),
        .B_00 (B_00),
        .B_01 (B_01),
        .B_1X (B_1X)
    ) u_sel (
        .clk     (clk),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .ratio_a (ratio_a),
        .ratio_b (ratio_b)
    );

    // Common advance strobe for both dividers.
    always_comb begin
        adv        = !hold_q;
        ratio_v[0] = ratio_a;
        ratio_v[1] = ratio_b;
    end

    // Shared launch flag: set on the first advancing edge after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launched_q <= 1'b0;
        end else if (adv) begin
            launched_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        localparam int LO = (g == 0) ? A_MIN : B_MIN;
        localparam int HI = (g == 0) ? A_MAX : B_MAX;
        twindiv_divider #(
            .RW    (RW),
            .MIN_R (LO),
            .MAX_R (HI)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv),
            .restart  (!launched_q),
            .ratio_in (ratio_v[g]),
            .q        (div_q[g])
        );
    end

    // Output pairs: true and complement.
    always_comb begin
        qa   = div_q[0];
        qa_n = ~div_q[0];
        qb   = div_q[1];
        qb_n = ~div_q[1];
    end

    // R4: the launch edge drives both outputs high together.
    p_launch_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!launched_q && adv) |=> (div_q == 2'b11))
        else $error("p_launch_aligned_r4");

    // R5: a captured pause keeps the launch flag where it was.
    p_hold_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> $stable(launched_q))
        else $error("p_hold_launch_r5");

endmodule

// File: tb/twindiv_top_test.sv
`timescale 1ns/1ps
module twindiv_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       freeze = 1'b0;
    logic       sel_a = 1'b0;
    logic [1:0] sel_b = 2'b00;
    logic       qa, qa_n, qb, qb_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state.
    bit         launched = 0;
    int         ph_a = 0, ph_b = 0, r_a = 2, r_b = 4;
    logic       exp_a = 1'b0, exp_b = 1'b0;
    logic       seen_a = 1'b0;
    logic [1:0] seen_b = 2'b00;
    logic       frz_neg = 1'b0;

    twindiv_top uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (freeze),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .qa     (qa),
        .qa_n   (qa_n),
        .qb     (qb),
        .qb_n   (qb_n)
    );

    always #2.5 clk = ~clk;

    // Freeze level seen at each falling edge.
    always @(negedge clk) frz_neg = freeze;

    function automatic int want_a(input logic s);
        return s ? 4 : 2;
    endfunction

    function automatic int want_b(input logic [1:0] c);
        if (c == 2'b00) return 4;
        if (c == 2'b01) return 6;
        return 5;
    endfunction

    task automatic check_out(input string tag);
        n_cmp++;
        if (qa_n !== ~qa || qb_n !== ~qb) begin
            n_bad++;
            $display("FAIL R9 (%s): qa=%b qa_n=%b qb=%b qb_n=%b expected complements",
                     tag, qa, qa_n, qb, qb_n);
        end else if (qa !== exp_a || qb !== exp_b) begin
            n_bad++;
            $display("FAIL %s: qa=%b qb=%b expected qa=%b qb=%b at %0t",
                     tag, qa, qb, exp_a, exp_b, $time);
        end
    endtask

    // One rising edge: update the model from the requirements, then check.
    task automatic tick(input string tag, input bit do_check);
        @(posedge clk);
        #2;
        if (!rst_n) begin
            launched = 0;
            exp_a = 1'b0;
            exp_b = 1'b0;
        end else if (!frz_neg) begin
            if (!launched || ph_a == r_a - 1) begin ph_a = 0; r_a = want_a(seen_a); end
            else ph_a++;
            if (!launched || ph_b == r_b - 1) begin ph_b = 0; r_b = want_b(seen_b); end
            else ph_b++;
            launched = 1;
            exp_a = (ph_a < r_a / 2);
            exp_b = (ph_b < r_b / 2);
        end
        seen_a = sel_a;
        seen_b = sel_b;
        if (do_check) check_out(tag);
    endtask

    task automatic do_reset(input logic sa, input logic [1:0] sb);
        sel_a  = sa;
        sel_b  = sb;
        freeze = 1'b0;
        rst_n  = 1'b0;
        tick("R3", 1);
        tick("R3", 1);
        rst_n = 1'b1;
    endtask

    // R3: reset state.
    task automatic t_reset_state();
        do_reset(1'b0, 2'b00);
        check_out("R3 reset state");
    endtask

    // R10: all control inputs low.
    task automatic t_defaults();
        do_reset(1'b0, 2'b00);
        for (int i = 0; i < 12; i++) tick("R10 defaults /2 and /4", 1);
    endtask

    // R1, R2, R4, R7: every ratio combination from a fresh launch.
    task automatic t_ratios();
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset(a[0], 2'(b));
                tick("R4 launch edge", 1);
                for (int i = 0; i < 23; i++) tick("R1 R2 R7 ratio pattern", 1);
            end
        end
    endtask

    // R3: reset acts without a clock edge.
    task automatic t_async_reset();
        do_reset(1'b1, 2'b01);
        for (int i = 0; i < 4; i++) tick("R2 run before reset", 1);
        rst_n = 1'b0;
        #0.2;
        launched = 0;
        exp_a = 1'b0;
        exp_b = 1'b0;
        check_out("R3 asynchronous reset");
        tick("R3", 1);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) tick("R4 R1 after async reset", 1);
    endtask

    // R5: held freeze pauses both outputs, release resumes.
    task automatic t_hold();
        do_reset(1'b1, 2'b10);
        for (int i = 0; i < 3; i++) tick("R2 pre-hold", 1);
        freeze = 1'b1;
        for (int i = 0; i < 4; i++) tick("R5 hold", 1);
        freeze = 1'b0;
        for (int i = 0; i < 8; i++) tick("R5 resume", 1);
    endtask

    // R5, R6: freeze pulses placed around the falling edge.
    task automatic t_glitches();
        do_reset(1'b0, 2'b11);
        for (int i = 0; i < 2; i++) tick("R2 pre-glitch", 1);
        freeze = 1'b1;
        #0.2;
        freeze = 1'b0;
        tick("R6 high-phase pulse ignored", 1);
        freeze = 1'b1;
        @(negedge clk);
        #1;
        freeze = 1'b0;
        tick("R5 pulse across falling edge holds", 1);
        for (int i = 0; i < 6; i++) tick("R5 after one-edge hold", 1);
    endtask

    // R8: ratio change mid-period completes the current period first.
    task automatic t_ratio_change();
        do_reset(1'b0, 2'b00);
        for (int i = 0; i < 2; i++) tick("R8 pre-change", 1);
        sel_b = 2'b01;
        sel_a = 1'b1;
        for (int i = 0; i < 14; i++) tick("R8 ratio change", 1);
        sel_b = 2'b10;
        for (int i = 0; i < 14; i++) tick("R8 second change", 1);
    endtask

    initial begin
        t_reset_state();
        t_defaults();
        t_ratios();
        t_async_reset();
        t_hold();
        t_glitches();
        t_ratio_change();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule